// File: doc/BRIEF.md
# Shared Instruction-Line Fetch Arbiter

Eight cores draw instructions from one instruction storage array that has two read ports. Each port returns a whole line of sixteen 32-bit instructions one cycle after it is addressed. Every core presents the address of its next fetch. A core whose local line buffer does not hold that line raises a request. The arbiter hands out the two ports to the requesting cores in a rotating order, one core per port. It then steers each returned line into the line buffer of the core it was read for.

A core keeps issuing instructions from its buffer for as long as its fetch address stays inside the buffered line, whether or not it holds a port. A per-core flush drops the buffered line. The next fetch must then go back to the array. Tag lookup, miss handling and the contents of the array are outside this block. The array is seen only through its two read ports.

Addresses are byte addresses of 32 bits. The line address is bits [31:6] of the fetch address, and the instruction within the line is selected by bits [5:2].

Top module: `iline_share_arb`

## Requirements
- R1: While `rst` is high, and in the first cycle after it, all line buffers are invalid (`core_hit` all zero). While `rst` is high no grant is given and no array port is read. The rotation starts at core 0, so the first grants after reset go to the lowest-numbered requesters.
- R2: A core whose buffer is valid and whose tag equals the line address of its `core_pc` is not granted.
- R3: At most two cores are granted per cycle, and they are always distinct. Port 0 is always used before port 1, so a lone requester is served on port 0 and `arr_rd_en` is `2'b01`.
- R4: Grants go to the first requesters found scanning upward, with wrap, from a rotation pointer. Port 0 takes the first of these and port 1 the second. After a cycle with any grant, the pointer moves to one past the last core granted. With no grant, it holds.
- R5: A core that requests in consecutive cycles is left ungranted for at most three of them.
- R6: For each granted port, `arr_rd_en` is high and `arr_rd_addr` carries bits [31:6] of the granted core's `core_pc`. For an idle port, `arr_rd_en` is low.
- R7: The line on `arr_rd_data` in the cycle after a grant is written into the granted core's buffer, together with a valid flag and the line address read. From the following cycle, `core_hit` is high and `core_instr` is word `core_pc[5:2]` of that line, taken from bits [32*w+31:32*w] of the line.
- R8: A core granted in one cycle is not granted in the next, because its fill is still in flight.
- R9: A `core_flush` pulse invalidates that core's buffer at the next edge, and the core then requests again. A flush in the cycle a fill arrives cancels that fill.
- R10: A core with a valid buffer keeps reporting `core_hit` with the correct word for any fetch address inside the buffered line while other cores hold both ports.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| core_pc | input | 256 | Next fetch byte address per core, core i in bits [32i+31:32i] |
| core_flush | input | 8 | Per-core buffer invalidate |
| core_hit | output | 8 | Buffer of core i holds the line of its fetch address |
| core_instr | output | 256 | Instruction at each core's fetch address, taken from its buffer |
| core_grant | output | 8 | One-hot-or-two set of cores granted this cycle |
| arr_rd_en | output | 2 | Read enable per array port |
| arr_rd_addr | output | 52 | Line address per port, port p in bits [26p+25:26p] |
| arr_rd_data | input | 1024 | Line returned per port, one cycle after the read, port p in bits [512p+511:512p] |

## Verification
The assertions watch the arbiter's structural promises on every cycle. These are: two grants never land on one core, port 1 is never used while port 0 is idle, a hitting core or a core with a fill in flight is never granted, and a flush or fill updates the buffer at the next edge. A per-core counter also enforces the three-cycle bound on waiting. Only the bench's scenarios can show three further things. The first is that the rotation order picks the exact cores expected after a run of earlier grants, including wrap past core 7. The second is that the line delivered really lands in the right core and yields the right word. The third is that a flush landing on an arriving fill leaves the buffer empty and triggers a second fetch.

// File: rtl/iline_pkg.sv
package iline_pkg;

    localparam int CORES      = 8;
    localparam int PORTS      = 2;
    localparam int LINE_WORDS = 16;
    localparam int WORD_W     = 32;
    localparam int ADDR_W     = 32;

    localparam int CORE_W  = $clog2(CORES);
    localparam int WSEL_W  = $clog2(LINE_WORDS);
    localparam int OFF_W   = WSEL_W + $clog2(WORD_W / 8);
    localparam int LADDR_W = ADDR_W - OFF_W;
    localparam int LINE_W  = LINE_WORDS * WORD_W;

    typedef logic [CORE_W-1:0]                   core_idx_t;
    typedef logic [LADDR_W-1:0]                  laddr_t;
    typedef logic [WORD_W-1:0]                   word_t;
    typedef logic [ADDR_W-1:0]                   addr_t;
    typedef logic [LINE_WORDS-1:0][WORD_W-1:0]   line_t;

    // One port's choice of core
    typedef struct packed {
        logic      vld;
        core_idx_t idx;
    } pick_t;

    // A read in flight: which core it belongs to and which line it reads
    typedef struct packed {
        logic      vld;
        core_idx_t core;
        laddr_t    tag;
    } fill_t;

    function automatic laddr_t line_of(input addr_t a);
        return a[ADDR_W-1:OFF_W];
    endfunction

    function automatic logic [WSEL_W-1:0] word_of(input addr_t a);
        return a[OFF_W-1:OFF_W-WSEL_W];
    endfunction

    // Lowest set bit of a request vector
    function automatic pick_t lowest_set(input logic [CORES-1:0] v);
        pick_t r;
        r = '0;
        for (int i = CORES - 1; i >= 0; i--) begin
            if (v[i]) begin
                r.vld = 1'b1;
                r.idx = core_idx_t'(i);
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/iline_rr_pick.sv
module iline_rr_pick
    import iline_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic [CORES-1:0]        req,
    output logic [CORES-1:0]        gnt,
    output pick_t [PORTS-1:0]       pick
);

    core_idx_t              ptr_q, ptr_d;
    logic [2*CORES-1:0]     dbl;
    logic [CORES-1:0]       rem;
    pick_t                  found;
    core_idx_t              gidx;

    always_comb begin
        dbl   = {req, req};
        rem   = dbl[ptr_q +: CORES];
        ptr_d = ptr_q;
        gnt   = '0;
        found = '0;
        gidx  = '0;
        pick  = '0;
        for (int p = 0; p < PORTS; p++) begin
            found = lowest_set(rem);
            if (found.vld) begin
                gidx           = ptr_q + found.idx;
                pick[p].vld    = 1'b1;
                pick[p].idx    = gidx;
                rem[found.idx] = 1'b0;
                gnt[gidx]      = 1'b1;
                ptr_d          = gidx + core_idx_t'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ptr_q <= '0;
        else     ptr_q <= ptr_d;
    end

    // Two grants in one cycle go to different cores (R3)
    p_distinct_r3: assert property (@(posedge clk) disable iff (rst)
        pick[1].vld |-> (pick[0].vld && pick[0].idx != pick[1].idx));

    p_grant_count_r3: assert property (@(posedge clk) disable iff (rst)
        $countones(gnt) <= PORTS);

    // Starvation bound, checked with a per-core wait counter (R5)
    for (genvar i = 0; i < CORES; i++) begin : g_wait
        logic [2:0] wait_q;
        always_ff @(posedge clk) begin
            if (rst)                    wait_q <= '0;
            else if (req[i] && !gnt[i]) wait_q <= wait_q + 3'd1;
            else                        wait_q <= '0;
        end
        p_wait_bound_r5: assert property (@(posedge clk) disable iff (rst)
            wait_q <= 3'd3);
    end

endmodule

// File: rtl/iline_core_buf.sv
module iline_core_buf
    import iline_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  addr_t   pc,
    input  logic    flush,
    input  logic    wr_en,
    input  laddr_t  wr_tag,
    input  line_t   wr_line,
    output logic    hit,
    output word_t   instr,
    output logic    req
);

    logic   valid_q;
    laddr_t tag_q;
    line_t  line_q;

    assign hit   = valid_q && (tag_q == line_of(pc));
    assign instr = line_q[word_of(pc)];
    // A fill arriving this cycle means the line is already on its way
    assign req   = !rst && !hit && !wr_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            tag_q   <= '0;
            line_q  <= '0;
        end else if (flush) begin
            valid_q <= 1'b0;
        end else if (wr_en) begin
            valid_q <= 1'b1;
            tag_q   <= wr_tag;
            line_q  <= wr_line;
        end
    end

    p_flush_clears_r9: assert property (@(posedge clk) disable iff (rst)
        flush |=> !valid_q);

    p_fill_sets_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !flush) |=> (valid_q && tag_q == $past(wr_tag)));

endmodule

// File: rtl/iline_share_arb.sv
module iline_share_arb
    import iline_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic [CORES*ADDR_W-1:0]      core_pc,
    input  logic [CORES-1:0]             core_flush,
    output logic [CORES-1:0]             core_hit,
    output logic [CORES*WORD_W-1:0]      core_instr,
    output logic [CORES-1:0]             core_grant,
    output logic [PORTS-1:0]             arr_rd_en,
    output logic [PORTS*LADDR_W-1:0]     arr_rd_addr,
    input  logic [PORTS*LINE_W-1:0]      arr_rd_data
);

    addr_t              pc_a    [CORES];
    logic [CORES-1:0]   req;
    pick_t [PORTS-1:0]  pick;
    fill_t              fill_q  [PORTS];
    logic [CORES-1:0]   wr_en;
    laddr_t             wr_tag  [CORES];
    line_t              wr_line [CORES];
    laddr_t             rd_line [PORTS];

    iline_rr_pick u_pick (
        .clk  (clk),
        .rst  (rst),
        .req  (req),
        .gnt  (core_grant),
        .pick (pick)
    );

    // Array read side and the record of what each port is fetching
    for (genvar p = 0; p < PORTS; p++) begin : g_port
        assign rd_line[p] = line_of(pc_a[pick[p].idx]);
        assign arr_rd_en[p] = pick[p].vld;
        assign arr_rd_addr[p*LADDR_W +: LADDR_W] = rd_line[p];

        always_ff @(posedge clk) begin
            if (rst) begin
                fill_q[p] <= '0;
            end else begin
                fill_q[p].vld  <= pick[p].vld;
                fill_q[p].core <= pick[p].idx;
                fill_q[p].tag  <= rd_line[p];
            end
        end
    end

    // Steering of returned lines into the owning core's buffer
    always_comb begin
        for (int i = 0; i < CORES; i++) begin
            wr_en[i]   = 1'b0;
            wr_tag[i]  = '0;
            wr_line[i] = '0;
            for (int p = 0; p < PORTS; p++) begin
                if (fill_q[p].vld && fill_q[p].core == core_idx_t'(i)) begin
                    wr_en[i]   = 1'b1;
                    wr_tag[i]  = fill_q[p].tag;
                    wr_line[i] = arr_rd_data[p*LINE_W +: LINE_W];
                end
            end
        end
    end

    for (genvar i = 0; i < CORES; i++) begin : g_core
        assign pc_a[i] = core_pc[i*ADDR_W +: ADDR_W];

        iline_core_buf u_buf (
            .clk     (clk),
            .rst     (rst),
            .pc      (pc_a[i]),
            .flush   (core_flush[i]),
            .wr_en   (wr_en[i]),
            .wr_tag  (wr_tag[i]),
            .wr_line (wr_line[i]),
            .hit     (core_hit[i]),
            .instr   (core_instr[i*WORD_W +: WORD_W]),
            .req     (req[i])
        );

        // A core already holding its line gets no port (R2)
        p_hit_no_grant_r2: assert property (@(posedge clk) disable iff (rst)
            core_hit[i] |-> !core_grant[i]);

        // No second grant while the first fill is in flight (R8)
        p_no_regrant_r8: assert property (@(posedge clk) disable iff (rst)
            core_grant[i] |=> !core_grant[i]);
    end

    // Port 1 is used only together with port 0 (R3)
    p_port_order_r3: assert property (@(posedge clk) disable iff (rst)
        arr_rd_en[1] |-> arr_rd_en[0]);

    // Nothing is read during reset (R1)
    p_reset_quiet_r1: assert property (@(posedge clk)
        rst |-> (arr_rd_en == '0 && core_grant == '0));

endmodule

// File: tb/iline_share_arb_tb.sv
module iline_share_arb_tb_top;
    import iline_pkg::*;

    logic                        clk = 1'b0;
    logic                        rst;
    logic [CORES*ADDR_W-1:0]     core_pc;
    logic [CORES-1:0]            core_flush;
    logic [CORES-1:0]            core_hit;
    logic [CORES*WORD_W-1:0]     core_instr;
    logic [CORES-1:0]            core_grant;
    logic [PORTS-1:0]            arr_rd_en;
    logic [PORTS*LADDR_W-1:0]    arr_rd_addr;
    logic [PORTS*LINE_W-1:0]     arr_rd_data;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    iline_share_arb dut_i (
        .clk         (clk),
        .rst         (rst),
        .core_pc     (core_pc),
        .core_flush  (core_flush),
        .core_hit    (core_hit),
        .core_instr  (core_instr),
        .core_grant  (core_grant),
        .arr_rd_en   (arr_rd_en),
        .arr_rd_addr (arr_rd_addr),
        .arr_rd_data (arr_rd_data)
    );

    // Array model: word w of line L is {L, 2'b00, w}
    function automatic word_t exp_word(input laddr_t l, input int w);
        return {l, 2'b00, 4'(w)};
    endfunction

    function automatic line_t mk_line(input laddr_t l);
        line_t r;
        for (int w = 0; w < LINE_WORDS; w++) r[w] = exp_word(l, w);
        return r;
    endfunction

    always_ff @(posedge clk) begin
        for (int p = 0; p < PORTS; p++) begin
            if (arr_rd_en[p])
                arr_rd_data[p*LINE_W +: LINE_W] <= mk_line(arr_rd_addr[p*LADDR_W +: LADDR_W]);
            else
                arr_rd_data[p*LINE_W +: LINE_W] <= '0;
        end
    end

    task automatic chk(input string rq, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic set_pc(input int c, input laddr_t l, input int w);
        core_pc[c*ADDR_W +: ADDR_W] = {l, 4'(w), 2'b00};
    endtask

    task automatic chk_core(input string rq, input int c, input laddr_t l, input int w);
        chk({rq, " hit"}, 64'(core_hit[c]), 64'd1);
        chk({rq, " instr"}, 64'(core_instr[c*WORD_W +: WORD_W]), 64'(exp_word(l, w)));
    endtask

    // Scoreboard of expected grant vectors, one entry per cycle
    typedef struct {
        logic [CORES-1:0] vec;
        string            rq;
    } exp_t;
    exp_t exp_q[$];

    task automatic expect_grant(input logic [CORES-1:0] v, input string rq);
        exp_t e;
        e.vec = v;
        e.rq  = rq;
        exp_q.push_back(e);
    endtask

    always @(negedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            chk({e.rq, " grant"}, 64'(core_grant), 64'(e.vec));
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        rst        = 1'b1;
        core_flush = '0;
        core_pc    = '0;
        for (int c = 0; c < CORES; c++) set_pc(c, laddr_t'(100 + c), c);
        repeat (3) @(negedge clk);
        #3;
        chk("R1 reset hit", 64'(core_hit), 64'd0);
        chk("R1 reset grant", 64'(core_grant), 64'd0);
        chk("R1 reset read", 64'(arr_rd_en), 64'd0);

        // A: all eight miss; pairs served in rotation, fills exclude re-grant
        @(negedge clk);
        rst = 1'b0;
        expect_grant(8'h03, "R1 R4 first pair");
        #3;
        chk("R6 rd_en", 64'(arr_rd_en), 64'd3);
        chk("R6 addr p0", 64'(arr_rd_addr[0 +: LADDR_W]), 64'd100);
        chk("R6 addr p1", 64'(arr_rd_addr[LADDR_W +: LADDR_W]), 64'd101);
        chk("R1 hit after reset", 64'(core_hit), 64'd0);
        @(negedge clk); expect_grant(8'h0C, "R8 R4 second pair");
        @(negedge clk); expect_grant(8'h30, "R4 third pair");
        @(negedge clk); expect_grant(8'hC0, "R5 fourth pair");
        @(negedge clk); expect_grant(8'h00, "R8 in flight");
        @(negedge clk); expect_grant(8'h00, "R2 all hit");
        #3;
        for (int c = 0; c < CORES; c++) chk_core("R7 fill", c, laddr_t'(100 + c), c);

        // B: a lone requester on port 0
        @(negedge clk);
        set_pc(5, laddr_t'(200), 3);
        expect_grant(8'h20, "R3 lone");
        #3;
        chk("R3 lone rd_en", 64'(arr_rd_en), 64'd1);
        chk("R6 lone addr", 64'(arr_rd_addr[0 +: LADDR_W]), 64'd200);
        @(negedge clk); expect_grant(8'h00, "R8 lone");
        @(negedge clk); expect_grant(8'h00, "R2 lone");
        #3;
        chk_core("R7 lone", 5, laddr_t'(200), 3);

        // C: wrap past core 7; core 0 keeps running from its buffer
        @(negedge clk);
        set_pc(7, laddr_t'(300), 5);
        set_pc(2, laddr_t'(301), 9);
        set_pc(0, laddr_t'(100), 7);
        expect_grant(8'h84, "R4 wrap");
        #3;
        chk("R4 wrap p0 addr", 64'(arr_rd_addr[0 +: LADDR_W]), 64'd300);
        chk("R4 wrap p1 addr", 64'(arr_rd_addr[LADDR_W +: LADDR_W]), 64'd301);
        chk_core("R10 buffered", 0, laddr_t'(100), 7);
        @(negedge clk); expect_grant(8'h00, "R8 wrap");
        @(negedge clk); expect_grant(8'h00, "R2 wrap");
        #3;
        chk_core("R7 wrap c7", 7, laddr_t'(300), 5);
        chk_core("R7 wrap c2", 2, laddr_t'(301), 9);

        // E: flush forces a refetch
        @(negedge clk);
        core_flush[4] = 1'b1;
        expect_grant(8'h00, "R9 flush cycle");
        @(negedge clk);
        core_flush[4] = 1'b0;
        expect_grant(8'h10, "R9 refetch");
        #3;
        chk("R9 flushed hit", 64'(core_hit[4]), 64'd0);
        @(negedge clk); expect_grant(8'h00, "R8 refetch");
        @(negedge clk); expect_grant(8'h00, "R2 refetch");
        #3;
        chk_core("R9 refilled", 4, laddr_t'(104), 4);

        // F: flush on the fill cycle cancels the fill
        @(negedge clk);
        set_pc(1, laddr_t'(400), 2);
        expect_grant(8'h02, "R9 pre-cancel");
        @(negedge clk);
        core_flush[1] = 1'b1;
        expect_grant(8'h00, "R8 pre-cancel");
        @(negedge clk);
        core_flush[1] = 1'b0;
        expect_grant(8'h02, "R9 cancelled fill refetch");
        #3;
        chk("R9 cancelled hit", 64'(core_hit[1]), 64'd0);
        @(negedge clk); expect_grant(8'h00, "R8 cancel");
        @(negedge clk); expect_grant(8'h00, "R2 cancel");
        #3;
        chk_core("R9 after cancel", 1, laddr_t'(400), 2);

        // G: three requesters, pointer at 2: 3 and 6 first, then 0
        @(negedge clk);
        set_pc(0, laddr_t'(500), 1);
        set_pc(3, laddr_t'(501), 2);
        set_pc(6, laddr_t'(502), 15);
        expect_grant(8'h48, "R4 three-way");
        @(negedge clk); expect_grant(8'h01, "R5 leftover");
        @(negedge clk); expect_grant(8'h00, "R8 leftover");
        @(negedge clk); expect_grant(8'h00, "R2 three-way");
        #3;
        chk_core("R7 c0", 0, laddr_t'(500), 1);
        chk_core("R7 c3", 3, laddr_t'(501), 2);
        chk_core("R7 c6", 6, laddr_t'(502), 15);

        @(negedge clk);
        #3;
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule